// File: doc/BRIEF.md
# Serial Clock-Chip Command Slave

This block is the device side of a one-wire-data, strobe-clocked link to a real-time clock chip. A host shifts a 16-bit transfer in one bit at a time: the first eight bits form a command byte, most significant bit first. The value of that byte alone sets the direction. On a write, the next eight input bits form a value that is committed when the sixteenth bit arrives. On a read, the return byte is picked as soon as the command byte is complete and is then driven out one bit per strobe.

The block holds 32 bytes of battery-style scratch RAM, a status byte and a control byte, and it selects among time-of-day fields that arrive already coded as BCD from a separate timekeeper. A power-interrupt output is raised by an external set input. It drops only when the host sends the dedicated clear command with the right value bit. A separate transfer-restart input clears the bit sequencer at any time without touching stored data.

Top module: `rtc_serial_slave`

## Requirements
- R1: Command bits are shifted in MSB first on the first eight strobes. Codes 0x80 to 0x9F and 0xB1 are writes; every other code is a read.
- R2: A read code 0x00 to 0x1F returns scratch RAM byte number `cmd`.
- R3: Read codes 0x20 to 0x2F return BCD time fields: 0x20 seconds, 0x21 minutes, 0x22 hours, 0x24 day of month, 0x25 month (1 to 12), 0x26 year (two digits). Every other code in that range returns 0x00.
- R4: Read 0x30 returns the status byte and 0x31 returns the control byte, which is fixed at 0x00. Read codes above 0x31 return 0x00.
- R5: On a read, the strobe of bit 8 puts bit 7 of the return byte on `data_out`, and each later strobe moves down one bit, so bit 15 carries bit 0. `data_out` changes one clock after the strobe and holds between strobes.
- R6: On a write code 0x80 to 0x9F, bits 8 to 15 form a value, MSB first, that is stored into RAM byte `cmd - 0x80` on the sixteenth strobe.
- R7: Write code 0xB1 with value bit 2 set clears status bits 4 and 3 and deasserts `pwr_irq`. With value bit 2 clear, it changes nothing.
- R8: After sixteen strobes, further strobes have no effect on state or on `data_out` until `xfer_rst` is asserted.
- R9: A `pwr_set` pulse sets `pwr_irq` and status bits 4 and 3. If it falls in the same cycle as an R7 clear, the set wins.
- R10: A synchronous active-low `rst_n` clears status, `pwr_irq`, `data_out` and the sequencer. RAM contents are not reset.
- R11: `xfer_rst` clears the bit phase, the command and the value without touching RAM or status. A strobe in the same cycle as `xfer_rst` is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_stb | input | 1 | One-cycle strobe marking a valid serial bit |
| bit_in | input | 1 | Serial input bit |
| xfer_rst | input | 1 | Restarts the transfer bit sequence |
| pwr_set | input | 1 | Raises the power interrupt and its status flags |
| sec_bcd | input | 8 | Seconds in BCD |
| min_bcd | input | 8 | Minutes in BCD |
| hour_bcd | input | 8 | Hours in BCD |
| mday_bcd | input | 8 | Day of month in BCD |
| mon_bcd | input | 8 | Month in BCD |
| year_bcd | input | 8 | Two-digit year in BCD |
| data_out | output | 1 | Serial read data |
| pwr_irq | output | 1 | Power interrupt |

## Verification
Two status actions can land on the same edge: an external `pwr_set` pulse and the commit of a 0xB1 clear on the sixteenth strobe. The bench raises `pwr_set` in exactly the cycle of that final strobe. It then expects `pwr_irq` to stay high and a later status read to return 0x18. A second case places `xfer_rst` in the same cycle as a strobe. The bench judges it by confirming that a transfer sent right after it decodes without being shifted by one bit.

// File: rtl/rtc_ser_pkg.sv
// Shared constants and command decode for the serial clock-chip slave.
// Assumes 8-bit command and data bytes and a 16-strobe transfer.
package rtc_ser_pkg;
    localparam int BYTE_W  = 8;
    localparam int PHASE_W = 5;
    localparam logic [PHASE_W-1:0] PH_CMD_LAST = 5'd7;
    localparam logic [PHASE_W-1:0] PH_VAL_LAST = 5'd15;
    localparam logic [PHASE_W-1:0] PH_DONE     = 5'd16;

    localparam logic [BYTE_W-1:0] OP_RAM_WR_LO = 8'h80;
    localparam logic [BYTE_W-1:0] OP_RAM_WR_HI = 8'h9F;
    localparam logic [BYTE_W-1:0] OP_FLAG_CLR  = 8'hB1;
    localparam logic [BYTE_W-1:0] OP_RAM_RD_HI = 8'h1F;
    localparam logic [BYTE_W-1:0] OP_TIME_LO   = 8'h20;
    localparam logic [BYTE_W-1:0] OP_TIME_HI   = 8'h2F;
    localparam logic [BYTE_W-1:0] OP_RD_STAT   = 8'h30;
    localparam logic [BYTE_W-1:0] OP_RD_CTRL   = 8'h31;

    localparam logic [BYTE_W-1:0] FLAG_PWR_MASK = 8'h18;
    localparam int CLR_KEY_BIT = 2;

    // True when the command code selects the write direction
    function automatic logic op_is_write(input logic [BYTE_W-1:0] c);
        return ((c >= OP_RAM_WR_LO) && (c <= OP_RAM_WR_HI)) || (c == OP_FLAG_CLR);
    endfunction
endpackage

// File: rtl/rtc_bit_seq.sv
// Bit sequencer: counts strobes, assembles the command and value bytes,
// and emits one-cycle event pulses for return latch, bit output and commit.
// Assumes bit_stb is a single-cycle enable in the clk domain.
module rtc_bit_seq
    import rtc_ser_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bit_stb,
    input  logic                bit_in,
    input  logic                xfer_rst,
    output logic [PHASE_W-1:0]  phase,
    output logic [BYTE_W-1:0]   cmd_q,
    output logic [BYTE_W-1:0]   cmd_nxt,
    output logic [BYTE_W-1:0]   val_nxt,
    output logic                latch_ret,
    output logic                shift_out,
    output logic                commit
);
    logic [BYTE_W-1:0] val_q;
    logic              adv;
    logic              in_cmd;

    // Decode whether this strobe advances the transfer and which event it is
    always_comb begin
        adv       = bit_stb && !xfer_rst && (phase < PH_DONE);
        in_cmd    = (phase <= PH_CMD_LAST);
        cmd_nxt   = {cmd_q[BYTE_W-2:0], bit_in};
        val_nxt   = {val_q[BYTE_W-2:0], bit_in};
        latch_ret = adv && (phase == PH_CMD_LAST) && !op_is_write(cmd_nxt);
        shift_out = adv && !in_cmd && !op_is_write(cmd_q);
        commit    = adv && (phase == PH_VAL_LAST) && op_is_write(cmd_q);
    end

    // Phase counter and command/value shift registers
    always_ff @(posedge clk) begin
        if (!rst_n || xfer_rst) begin
            phase <= '0;
            cmd_q <= '0;
            val_q <= '0;
        end else if (adv) begin
            phase <= phase + 1'b1;
            if (in_cmd)
                cmd_q <= cmd_nxt;
            else if (op_is_write(cmd_q))
                val_q <= val_nxt;
        end
    end

    p_phase_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        phase <= PH_DONE);
    p_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DONE && !xfer_rst) |=> (phase == PH_DONE) && $stable(cmd_q));
    p_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_rst |=> (phase == '0) && (cmd_q == '0));
    p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_stb && !xfer_rst) |=> $stable(phase) && $stable(cmd_q));
endmodule

// File: rtl/rtc_store.sv
// Storage: scratch RAM (not reset, battery-style), status flags and the
// power interrupt. Set from pwr_set has priority over the clear action.
module rtc_store
    import rtc_ser_pkg::*;
#(
    parameter int RAM_AW = 5
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [RAM_AW-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [RAM_AW-1:0] rd_addr,
    input  logic              flag_clr,
    input  logic              pwr_set,
    output logic [BYTE_W-1:0] rd_data,
    output logic [BYTE_W-1:0] status,
    output logic [BYTE_W-1:0] control,
    output logic              pwr_irq
);
    localparam int RAM_DEPTH = 1 << RAM_AW;
    localparam logic [BYTE_W-1:0] CTRL_INIT = '0;

    logic [BYTE_W-1:0] mem [RAM_DEPTH];

    // Scratch RAM write port; contents survive rst_n
    always_ff @(posedge clk) begin
        if (wr_en)
            mem[wr_addr] <= wr_data;
    end

    // Asynchronous read for return-byte selection
    assign rd_data = mem[rd_addr];
    assign control = CTRL_INIT;

    // Status flags and power interrupt, set dominant over clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status  <= '0;
            pwr_irq <= 1'b0;
        end else if (pwr_set) begin
            status  <= status | FLAG_PWR_MASK;
            pwr_irq <= 1'b1;
        end else if (flag_clr) begin
            status  <= status & ~FLAG_PWR_MASK;
            pwr_irq <= 1'b0;
        end
    end

    p_irq_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_set |=> pwr_irq && (status[4:3] == 2'b11));
    p_irq_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(pwr_irq) && $past(rst_n)) |-> $past(flag_clr));
    p_flags_track_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_irq == (status[4:3] == 2'b11));
endmodule

// File: rtl/rtc_read_sel.sv
// Return-byte selector: maps a read command code to RAM, time, status or
// control data. Purely combinational; unmapped codes yield zero.
module rtc_read_sel
    import rtc_ser_pkg::*;
(
    input  logic [BYTE_W-1:0] cmd,
    input  logic [BYTE_W-1:0] ram_data,
    input  logic [BYTE_W-1:0] status,
    input  logic [BYTE_W-1:0] control,
    input  logic [BYTE_W-1:0] sec_bcd,
    input  logic [BYTE_W-1:0] min_bcd,
    input  logic [BYTE_W-1:0] hour_bcd,
    input  logic [BYTE_W-1:0] mday_bcd,
    input  logic [BYTE_W-1:0] mon_bcd,
    input  logic [BYTE_W-1:0] year_bcd,
    output logic [BYTE_W-1:0] ret
);
    logic [BYTE_W-1:0] time_val;

    // Time field select by the low nibble of the code
    always_comb begin
        case (cmd[3:0])
            4'h0:    time_val = sec_bcd;
            4'h1:    time_val = min_bcd;
            4'h2:    time_val = hour_bcd;
            4'h4:    time_val = mday_bcd;
            4'h5:    time_val = mon_bcd;
            4'h6:    time_val = year_bcd;
            default: time_val = '0;
        endcase
    end

    // Range decode of the read code
    always_comb begin
        if (cmd <= OP_RAM_RD_HI)
            ret = ram_data;
        else if (cmd >= OP_TIME_LO && cmd <= OP_TIME_HI)
            ret = time_val;
        else if (cmd == OP_RD_STAT)
            ret = status;
        else if (cmd == OP_RD_CTRL)
            ret = control;
        else
            ret = '0;
    end
endmodule

// File: rtl/rtc_serial_slave.sv
// Top: serial command slave for a real-time clock chip. Ties the bit
// sequencer, the storage and the read selector, and owns the return byte
// and the serial output register.
module rtc_serial_slave
    import rtc_ser_pkg::*;
#(
    parameter int RAM_AW = 5
)(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_stb,
    input  logic       bit_in,
    input  logic       xfer_rst,
    input  logic       pwr_set,
    input  logic [7:0] sec_bcd,
    input  logic [7:0] min_bcd,
    input  logic [7:0] hour_bcd,
    input  logic [7:0] mday_bcd,
    input  logic [7:0] mon_bcd,
    input  logic [7:0] year_bcd,
    output logic       data_out,
    output logic       pwr_irq
);
    logic [PHASE_W-1:0] phase;
    logic [BYTE_W-1:0]  cmd_q, cmd_nxt, val_nxt;
    logic               latch_ret, shift_out, commit;
    logic [BYTE_W-1:0]  ram_data, status, control, ret_sel;
    logic [BYTE_W-1:0]  ret_q;
    logic               ram_wr, flag_clr;
    logic [2:0]         out_idx;

    rtc_bit_seq u_seq (
        .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .bit_in(bit_in),
        .xfer_rst(xfer_rst), .phase(phase), .cmd_q(cmd_q), .cmd_nxt(cmd_nxt),
        .val_nxt(val_nxt), .latch_ret(latch_ret), .shift_out(shift_out),
        .commit(commit)
    );

    // Commit decode: RAM store window or the flag-clear key
    always_comb begin
        ram_wr   = commit && (cmd_q >= OP_RAM_WR_LO) && (cmd_q <= OP_RAM_WR_HI);
        flag_clr = commit && (cmd_q == OP_FLAG_CLR) && val_nxt[CLR_KEY_BIT];
        out_idx  = 3'd7 - phase[2:0];
    end

    rtc_store #(.RAM_AW(RAM_AW)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(ram_wr), .wr_addr(cmd_q[RAM_AW-1:0]),
        .wr_data(val_nxt), .rd_addr(cmd_nxt[RAM_AW-1:0]), .flag_clr(flag_clr),
        .pwr_set(pwr_set), .rd_data(ram_data), .status(status),
        .control(control), .pwr_irq(pwr_irq)
    );

    rtc_read_sel u_sel (
        .cmd(cmd_nxt), .ram_data(ram_data), .status(status), .control(control),
        .sec_bcd(sec_bcd), .min_bcd(min_bcd), .hour_bcd(hour_bcd),
        .mday_bcd(mday_bcd), .mon_bcd(mon_bcd), .year_bcd(year_bcd),
        .ret(ret_sel)
    );

    // Return byte capture on the last command bit, serial output per strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ret_q    <= '0;
            data_out <= 1'b0;
        end else begin
            if (latch_ret)
                ret_q <= ret_sel;
            if (shift_out)
                data_out <= ret_q[out_idx];
        end
    end

    p_dout_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_stb |=> $stable(data_out));
    p_one_event_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({latch_ret, shift_out, commit}) <= 1);
    p_write_no_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> !shift_out && !latch_ret);
endmodule

// File: tb/tb_rtc_serial_slave.sv
module tb_rtc_serial_slave;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_stb = 1'b0, bit_in = 1'b0, xfer_rst = 1'b0, pwr_set = 1'b0;
    logic [7:0] sec_bcd = 8'h0, min_bcd = 8'h0, hour_bcd = 8'h0;
    logic [7:0] mday_bcd = 8'h1, mon_bcd = 8'h1, year_bcd = 8'h0;
    logic       data_out, pwr_irq;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    logic [7:0] ram_m [32];
    logic [7:0] stat_m = 8'h00;
    logic       irq_m  = 1'b0;

    always #5 clk = ~clk;

    rtc_serial_slave dut (
        .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .bit_in(bit_in),
        .xfer_rst(xfer_rst), .pwr_set(pwr_set), .sec_bcd(sec_bcd),
        .min_bcd(min_bcd), .hour_bcd(hour_bcd), .mday_bcd(mday_bcd),
        .mon_bcd(mon_bcd), .year_bcd(year_bcd), .data_out(data_out),
        .pwr_irq(pwr_irq)
    );

    function automatic logic [7:0] to_bcd(input int n);
        return {4'(n / 10), 4'(n % 10)};
    endfunction

    function automatic bit is_wr(input logic [7:0] c);
        return (c >= 8'h80 && c <= 8'h9F) || c == 8'hB1;
    endfunction

    function automatic logic [7:0] exp_read(input logic [7:0] c);
        if (c <= 8'h1F) return ram_m[c[4:0]];
        if (c >= 8'h20 && c <= 8'h2F) begin
            case (c)
                8'h20: return sec_bcd;
                8'h21: return min_bcd;
                8'h22: return hour_bcd;
                8'h24: return mday_bcd;
                8'h25: return mon_bcd;
                8'h26: return year_bcd;
                default: return 8'h00;
            endcase
        end
        if (c == 8'h30) return stat_m;
        return 8'h00;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic randomize_time();
        sec_bcd  = to_bcd($urandom % 60);
        min_bcd  = to_bcd($urandom % 60);
        hour_bcd = to_bcd($urandom % 24);
        mday_bcd = to_bcd(1 + $urandom % 31);
        mon_bcd  = to_bcd(1 + $urandom % 12);
        year_bcd = to_bcd($urandom % 100);
    endtask

    // Restart pulse; optionally with a same-cycle strobe carrying a 1 (R11)
    task automatic restart(input bit with_stb);
        @(negedge clk);
        xfer_rst = 1'b1;
        bit_stb  = with_stb;
        bit_in   = 1'b1;
        @(negedge clk);
        xfer_rst = 1'b0;
        bit_stb  = 1'b0;
    endtask

    // Sixteen-bit transfer; collect read bits; optional pwr_set on last strobe
    task automatic xfer(input logic [7:0] c, input logic [7:0] v, input bit collide,
                        output logic [7:0] rd);
        logic [15:0] word;
        word = {c, v};
        rd = 8'h00;
        for (int k = 0; k < 16; k++) begin
            repeat ($urandom % 3) @(negedge clk);
            bit_in  = word[15 - k];
            bit_stb = 1'b1;
            if (k == 15 && collide) pwr_set = 1'b1;
            @(negedge clk);
            bit_stb = 1'b0;
            pwr_set = 1'b0;
            if (k >= 8) rd[15 - k] = data_out;
        end
        if (c >= 8'h80 && c <= 8'h9F) ram_m[c[4:0]] = v;
        if (c == 8'hB1 && v[2] && !collide) begin
            stat_m = stat_m & ~8'h18;
            irq_m  = 1'b0;
        end
        if (collide) begin
            stat_m = stat_m | 8'h18;
            irq_m  = 1'b1;
        end
    endtask

    task automatic do_read(input logic [7:0] c, input string req);
        logic [7:0] rd, ex;
        restart(1'b0);
        ex = exp_read(c);
        xfer(c, 8'h00, 1'b0, rd);
        chk(rd === ex, req, rd, ex);
    endtask

    task automatic do_write(input logic [7:0] c, input logic [7:0] v);
        logic [7:0] rd;
        restart(1'b0);
        xfer(c, v, 1'b0, rd);
    endtask

    task automatic pulse_set();
        @(negedge clk);
        pwr_set = 1'b1;
        @(negedge clk);
        pwr_set = 1'b0;
        stat_m = stat_m | 8'h18;
        irq_m  = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd, d_before;
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < 32; i++) ram_m[i] = 8'h00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        chk(data_out === 1'b0, "R10 data_out", {7'b0, data_out}, 8'h00);
        chk(pwr_irq === 1'b0, "R10 pwr_irq", {7'b0, pwr_irq}, 8'h00);
        do_read(8'h30, "R10 status after reset");
        do_read(8'h31, "R4 control read");
        // Fill RAM so reads are defined (R6)
        for (int i = 0; i < 32; i++) do_write(8'h80 + 8'(i), 8'($urandom));
        do_read(8'h00, "R2 RAM low edge");
        do_read(8'h1F, "R2 RAM high edge");
        do_write(8'h9F, 8'hA5);
        do_read(8'h1F, "R6 write top of window");
        do_write(8'h80, 8'h5A);
        do_read(8'h00, "R6 write bottom of window");
        // R3: every time code
        randomize_time();
        for (int c = 8'h20; c <= 8'h2F; c++) do_read(8'(c), "R3 time field");
        // R4: unmapped read codes
        do_read(8'h32, "R4 unmapped read");
        do_read(8'hA0, "R1 0xA0 is a read");
        do_read(8'hB0, "R1 0xB0 is a read");
        do_read(8'hB2, "R1 0xB2 is a read");
        // R9 / R7
        pulse_set();
        chk(pwr_irq === 1'b1, "R9 irq set", {7'b0, pwr_irq}, 8'h01);
        do_read(8'h30, "R9 status flags");
        do_write(8'hB1, 8'hFB);
        chk(pwr_irq === 1'b1, "R7 key bit clear no effect", {7'b0, pwr_irq}, 8'h01);
        do_read(8'h30, "R7 status kept");
        do_write(8'hB1, 8'h04);
        chk(pwr_irq === 1'b0, "R7 irq dropped", {7'b0, pwr_irq}, 8'h00);
        do_read(8'h30, "R7 status cleared");
        // R9: collision, set wins
        restart(1'b0);
        xfer(8'hB1, 8'h04, 1'b1, rd);
        chk(pwr_irq === 1'b1, "R9 set beats clear", {7'b0, pwr_irq}, 8'h01);
        do_read(8'h30, "R9 status after collision");
        // R8: extra strobes ignored after 16 bits
        restart(1'b0);
        xfer(8'h07, 8'h00, 1'b0, rd);
        chk(rd === ram_m[7], "R5 serial read", rd, ram_m[7]);
        d_before = {7'b0, data_out};
        for (int k = 0; k < 10; k++) begin
            @(negedge clk); bit_in = k[0]; bit_stb = 1'b1;
            @(negedge clk); bit_stb = 1'b0;
        end
        chk({7'b0, data_out} === d_before, "R8 data_out frozen", {7'b0, data_out}, d_before);
        restart(1'b0);
        xfer(8'h83, 8'h3C, 1'b0, rd);
        for (int k = 0; k < 8; k++) begin
            @(negedge clk); bit_in = 1'b1; bit_stb = 1'b1;
            @(negedge clk); bit_stb = 1'b0;
        end
        do_read(8'h03, "R8 value not overwritten");
        // R11: strobe in same cycle as restart is dropped
        restart(1'b1);
        xfer(8'h05, 8'h00, 1'b0, rd);
        chk(rd === ram_m[5], "R11 strobe with restart dropped", rd, ram_m[5]);
        // R11: partial transfer then restart leaves RAM
        restart(1'b0);
        for (int k = 0; k < 12; k++) begin
            @(negedge clk); bit_in = 1'b1; bit_stb = 1'b1;
            @(negedge clk); bit_stb = 1'b0;
        end
        do_read(8'h1F, "R11 partial write aborted");
        // R10: rst_n keeps RAM
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        stat_m = 8'h00; irq_m = 1'b0;
        chk(pwr_irq === 1'b0, "R10 irq after reset", {7'b0, pwr_irq}, 8'h00);
        do_read(8'h05, "R10 RAM survives reset");
        // Random mix
        for (int n = 0; n < 150; n++) begin
            int sel;
            sel = $urandom % 6;
            randomize_time();
            case (sel)
                0: do_write(8'h80 + 8'($urandom % 32), 8'($urandom));
                1: do_read(8'($urandom % 32), "R2 random RAM read");
                2: do_read(8'h20 + 8'($urandom % 16), "R3 random time read");
                3: begin
                    if ($urandom % 2) pulse_set();
                    do_read(8'h30, "R9 random status read");
                end
                4: begin
                    do_write(8'hB1, 8'($urandom));
                    chk(pwr_irq === irq_m, "R7 random clear", {7'b0, pwr_irq}, {7'b0, irq_m});
                end
                default: do_read(8'h32 + 8'($urandom % 78), "R4 random unmapped read");
            endcase
        end
        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule